// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. A 16-bit counter counts up, one step per prescaled tick. When it wraps past its all-ones value, the block pulses a reset request. Software keeps the system alive by reloading the counter before it wraps. To program a timeout of N ticks, software loads 65536 − N. Loading the all-ones value while counting is enabled forces a reset request on the very next tick.

Each register write must carry a fixed key pattern in its upper bits. A write with the wrong key changes no state and raises a one-cycle error strobe. After every accepted write, the block stays busy for a short fixed window. A status bit reports this window, and any write that arrives during it is dropped. A sticky flag records that a watchdog reset has taken place. Only the power-on reset or an explicit keyed clear removes it, so it is still set after the system comes back from the watchdog reset.

Top module: `key_wdt`

## Requirements
- R1: Word 0 (bus_addr[3:2]=0) is the counter. A write there is accepted only when bus_wdata[31:16]=0x5A5A, and it loads bus_wdata[15:0]. Reading word 0 returns the live count in bits 15:0, with zeros above.
- R2: Words 1 (control) and 2 (spare byte) accept a write only when bus_wdata[31:8]=0xA5A5A5, and they take bus_wdata[7:0]. The control word has enable in bit 7, busy in bit 5 (read-only), the overflow flag in bit 4 and the divisor select in bits 2:0. Control bits 6 and 3 read as 0. The spare byte reads back exactly as written.
- R3: A write to words 0–2 with a wrong key leaves every register unchanged. It sets key_err high for exactly the one cycle after the write edge.
- R4: After an accepted write, busy (control bit 5) reads 1 for 2 cycles. A write during that window is dropped and raises no key_err. The next write is accepted on the third edge.
- R5: Divisor select values 0..7 give 1, 4, 16, 32, 64, 128, 1024 and 4096 input cycles per tick. The prescaler restarts on an accepted counter or control write.
- R6: While enabled, the counter increments once per tick. While disabled, it holds its value. Loading 65536−N and then enabling produces the overflow on the Nth tick.
- R7: Loading 0xFFFF while enabled produces the overflow on the next tick.
- R8: On overflow the counter wraps to 0 and keeps counting, and wdt_rst goes high for 16 cycles starting just after the overflow edge.
- R9: An overflow sets the control flag in bit 4. The flag clears only on rst_n or on a keyed control write with bit 4 = 0; writing 1 there leaves it as it was. An overflow that lands on the same edge as a clearing write leaves the flag set.
- R10: After rst_n, every register reads 0 and key_err and wdt_rst are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data, including the key |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| key_err | output | 1 | One-cycle strobe for a write with a wrong key |
| wdt_rst | output | 1 | Reset request pulse on overflow |

## Verification
The overflow that sets the sticky flag and a keyed control write that clears it can land on the same clock edge. The bench provokes this with the divisor set to 4 and 0xFFFF loaded into the counter. It then times the control write (enable, divisor 4, bit 4 = 0) so that it lands exactly four edges later, on the tick edge. The result is judged by reading the control word just after that edge: the flag must still be set, the newly written fields must be present, busy must show, and the reset pulse must be active.

// File: rtl/key_wdt.sv
module key_wdt #(
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 12,
  parameter int BUSY_CYC  = 2,
  parameter int PULSE_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        key_err,
  output logic        wdt_rst
);
  localparam logic [15:0] CNT_KEY = 16'h5A5A;
  localparam logic [23:0] CSR_KEY = 24'hA5A5A5;
  localparam int BUSY_W  = $clog2(BUSY_CYC + 1);
  localparam int PULSE_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0]   cnt;
  logic [PRE_W-1:0]   pre;
  logic               en, ovf, key_err_q;
  logic [2:0]         sel;
  logic [7:0]         spare;
  logic [BUSY_W-1:0]  busy_cnt;
  logic [PULSE_W-1:0] pulse_cnt;

  function automatic logic [PRE_W-1:0] div_m1(input logic [2:0] s);
    case (s)
      3'd0:    div_m1 = PRE_W'(0);
      3'd1:    div_m1 = PRE_W'(3);
      3'd2:    div_m1 = PRE_W'(15);
      3'd3:    div_m1 = PRE_W'(31);
      3'd4:    div_m1 = PRE_W'(63);
      3'd5:    div_m1 = PRE_W'(127);
      3'd6:    div_m1 = PRE_W'(1023);
      default: div_m1 = PRE_W'(4095);
    endcase
  endfunction

  wire busy    = busy_cnt != '0;
  wire a_cnt   = bus_addr[3:2] == 2'd0;
  wire a_ctl   = bus_addr[3:2] == 2'd1;
  wire a_spr   = bus_addr[3:2] == 2'd2;
  wire mapped  = a_cnt || a_ctl || a_spr;
  wire key_ok  = a_cnt ? (bus_wdata[31:16] == CNT_KEY) : (bus_wdata[31:8] == CSR_KEY);
  wire live    = bus_wr && !busy && mapped;
  wire acc     = live && key_ok;
  wire bad     = live && !key_ok;
  wire tick    = en && (pre == div_m1(sel));
  wire wrap    = tick && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      pre       <= '0;
      en        <= 1'b0;
      sel       <= 3'd0;
      ovf       <= 1'b0;
      spare     <= 8'd0;
      busy_cnt  <= '0;
      pulse_cnt <= '0;
      key_err_q <= 1'b0;
    end else begin
      key_err_q <= bad;

      if (!en || tick || (acc && (a_cnt || a_ctl))) pre <= '0;
      else                                          pre <= pre + 1'b1;

      if (acc && a_cnt) cnt <= bus_wdata[CNT_W-1:0];
      else if (tick)    cnt <= cnt + 1'b1;

      if (acc && a_ctl) begin
        en  <= bus_wdata[7];
        sel <= bus_wdata[2:0];
      end

      if (wrap)                            ovf <= 1'b1;
      else if (acc && a_ctl && !bus_wdata[4]) ovf <= 1'b0;

      if (acc && a_spr) spare <= bus_wdata[7:0];

      if (acc)       busy_cnt <= BUSY_W'(BUSY_CYC);
      else if (busy) busy_cnt <= busy_cnt - 1'b1;

      if (wrap)                   pulse_cnt <= PULSE_W'(PULSE_CYC);
      else if (pulse_cnt != '0)   pulse_cnt <= pulse_cnt - 1'b1;
    end
  end

  always_comb begin
    case (bus_addr[3:2])
      2'd0:    bus_rdata = 32'(cnt);
      2'd1:    bus_rdata = {24'd0, en, 1'b0, busy, ovf, 1'b0, sel};
      2'd2:    bus_rdata = {24'd0, spare};
      default: bus_rdata = 32'd0;
    endcase
  end

  assign key_err = key_err_q;
  assign wdt_rst = pulse_cnt != '0;
endmodule

// File: rtl/key_wdt_chk.sv
module key_wdt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        key_err,
  input logic        wdt_rst,
  input logic [15:0] cnt,
  input logic        en,
  input logic        ovf,
  input logic        busy
);
  wire free_wr = bus_wr && !busy;

  assert_cnt_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (free_wr && bus_addr[3:2] == 2'd0 && bus_wdata[31:16] == 16'h5A5A)
    |=> (cnt == $past(bus_wdata[15:0])));

  assert_bad_key_ctl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (free_wr && bus_addr[3:2] == 2'd1 && bus_wdata[31:8] != 24'hA5A5A5)
    |=> ($stable(en) && key_err));

  assert_busy_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (free_wr && ((bus_addr[3:2] == 2'd0 && bus_wdata[31:16] == 16'h5A5A) ||
                 (bus_addr[3:2] != 2'd0 && bus_addr[3:2] != 2'd3 && bus_wdata[31:8] == 24'hA5A5A5)))
    |=> busy);

  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !(free_wr && bus_addr[3:2] == 2'd0)) |=> $stable(cnt));

  assert_rst_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> ovf);
endmodule

bind key_wdt key_wdt_chk u_key_wdt_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .key_err(key_err), .wdt_rst(wdt_rst),
  .cnt(cnt), .en(en), .ovf(ovf), .busy(busy)
);

// File: tb/test_key_wdt.sv
module test_key_wdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        key_err, wdt_rst;
  int checks = 0;
  int errors = 0;

  key_wdt i_key_wdt (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                     .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_err(key_err),
                     .wdt_rst(wdt_rst));

  always #5 clk = ~clk;

  // {addr, wdata, expected readback, expected key_err}
  localparam int NV = 9;
  localparam logic [68:0] VEC [NV] = '{
    {4'h0, 32'h5A5A1234, 32'h00001234, 1'b0},   // R1
    {4'h0, 32'h5A5B0077, 32'h00001234, 1'b1},   // R3
    {4'h8, 32'hA5A5A5C3, 32'h000000C3, 1'b0},   // R2
    {4'h8, 32'hA5A5A4FF, 32'h000000C3, 1'b1},   // R3
    {4'h4, 32'hA5A5A506, 32'h00000006, 1'b0},   // R2
    {4'h4, 32'hA5A5A54D, 32'h00000005, 1'b0},   // R2 bits 6,3 dropped
    {4'h0, 32'hA5A5A5FF, 32'h00001234, 1'b1},   // R3 wrong key type
    {4'h4, 32'h5A5A5A80, 32'h00000005, 1'b1},   // R3
    {4'h0, 32'h5A5AFFFE, 32'h0000FFFE, 1'b0}    // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // called at a negedge; the next posedge takes the write; returns at the following negedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wr_wait(input logic [3:0] a, input logic [31:0] d);
    wr(a, d);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_sim();
      end
    end
  end

  initial begin
    logic [31:0] v;
    int n, len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(4'h0, v); check("R10 cnt", v, 0);
    rd(4'h4, v); check("R10 ctl", v, 0);
    rd(4'h8, v); check("R10 spare", v, 0);
    check("R10 outs", {30'd0, key_err, wdt_rst}, 0);
    @(negedge clk);

    // table of keyed and mis-keyed writes (R1 R2 R3)
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][68:65], VEC[i][64:33]);
      check("R3 key_err strobe", {31'd0, key_err}, {31'd0, VEC[i][0]});
      @(negedge clk);
      check("R3 key_err one cycle", {31'd0, key_err}, 0);
      @(negedge clk);
      rd(VEC[i][68:65], v);
      check("R1/R2 readback", v, VEC[i][32:1]);
      @(negedge clk);
    end

    // R4 busy window and dropped write
    wr(4'h8, 32'hA5A5A511);
    rd(4'h4, v); check("R4 busy set", v & 32'h20, 32'h20);
    wr(4'h8, 32'hA5A5A522);
    check("R4 dropped no err", {31'd0, key_err}, 0);
    rd(4'h4, v); check("R4 busy second cycle", v & 32'h20, 32'h20);
    @(negedge clk);
    rd(4'h4, v); check("R4 busy clear", v & 32'h20, 0);
    rd(4'h8, v); check("R4 spare unchanged", v, 32'h11);

    // R6 disabled counter holds
    wr_wait(4'h4, 32'hA5A5A500);
    wr_wait(4'h0, 32'h5A5A0100);
    repeat (20) @(negedge clk);
    rd(4'h0, v); check("R6 hold when disabled", v, 32'h100);

    // R6 timeout of 16 ticks at divisor 1
    wr_wait(4'h0, 32'h5A5AFFF0);
    wr(4'h4, 32'hA5A5A580);
    n = 0;
    for (int k = 0; k < 40 && !wdt_rst; k++) begin @(posedge clk); #1 n++; end
    check("R6 overflow at tick 16", n, 16);
    len = 1;
    for (int k = 0; k < 24; k++) begin @(posedge clk); #1 if (wdt_rst) len++; end
    check("R8 pulse length", len, 16);
    @(negedge clk);
    rd(4'h0, v); check("R8 wrapped and counting", v, 32'd24);
    rd(4'h4, v); check("R9 flag set", v, 32'h90);

    // R9 writing 1 keeps the flag, writing 0 clears it
    wr_wait(4'h4, 32'hA5A5A510);
    rd(4'h4, v); check("R9 write 1 keeps", v, 32'h10);
    wr_wait(4'h4, 32'hA5A5A500);
    rd(4'h4, v); check("R9 write 0 clears", v, 32'h00);

    // R5 divisor 4: two ticks from 0xFFFE
    wr_wait(4'h0, 32'h5A5AFFFE);
    wr(4'h4, 32'hA5A5A581);
    n = 0;
    for (int k = 0; k < 40 && !wdt_rst; k++) begin @(posedge clk); #1 n++; end
    check("R5 divisor 4 timing", n, 8);
    repeat (20) @(negedge clk);

    // R5 divisor 16: one tick from 0xFFFF loaded while disabled
    wr_wait(4'h4, 32'hA5A5A500);
    wr_wait(4'h0, 32'h5A5AFFFF);
    wr(4'h4, 32'hA5A5A582);
    n = 0;
    for (int k = 0; k < 40 && !wdt_rst; k++) begin @(posedge clk); #1 n++; end
    check("R5 divisor 16 timing", n, 16);
    repeat (20) @(negedge clk);

    // R6 live count read at divisor 1
    wr_wait(4'h4, 32'hA5A5A580);
    wr(4'h0, 32'h5A5A0000);
    repeat (10) @(negedge clk);
    rd(4'h0, v); check("R6 live count", v, 32'd10);

    // R7 immediate restart
    wr(4'h0, 32'h5A5AFFFF);
    n = 0;
    for (int k = 0; k < 40 && !wdt_rst; k++) begin @(posedge clk); #1 n++; end
    check("R7 next tick overflow", n, 1);
    repeat (20) @(negedge clk);

    // R9 overflow and clearing write on the same edge
    wr_wait(4'h4, 32'hA5A5A581);
    rd(4'h4, v); check("R9 pre-clear", v, 32'h81);
    wr(4'h0, 32'h5A5AFFFF);
    repeat (3) @(negedge clk);
    check("R9 no early pulse", {31'd0, wdt_rst}, 0);
    wr(4'h4, 32'hA5A5A581);
    rd(4'h4, v); check("R9 set wins over clear", v, 32'hB1);
    check("R8 pulse on collision", {31'd0, wdt_rst}, 1);

    finish_sim();
  end
endmodule